// File: doc/BRIEF.md
# Firmware Configuration Item Port

This block is a memory-mapped slave that serves a fixed set of read-only firmware configuration items. Every item has a 16-bit key. Software writes a key into the selector register, which also rewinds the read position. It then pulls the item out one byte per read of the data register, and the position moves forward after each read. Two keys are reserved. One returns a four-byte signature. The other returns a little-endian feature word whose bit 1 reports that a descriptor-driven transfer engine is attached. A further range of keys holds user items whose contents are computed from parameters.

The same selector and offset state is also driven by side ports meant for a transfer engine. These ports can select an item, skip forward by a byte count, and fetch the byte at the current position. While any side port is active, the bus is held off. The transfer-address register does not start anything here. A read of it returns a fixed identification value, so that software can detect the engine.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the current key is 0x0000 and the offset is 0. `rsp_valid_o` is low, `req_ready_o` is high, and `dma_byte_o` shows 0x51.
- R2: The register map uses byte addresses. Addresses 0x00–0x07 reach the data register, 0x08–0x09 the selector, and 0x10–0x17 the transfer-address register. A read of any other address returns zero. A write to any other address changes nothing.
- R3: A selector write loads the key from `req_wdata_i[15:0]` and ignores the upper data bits. It also sets the offset to 0. A selector read returns the current key in bits [15:0], with zero above.
- R4: A data-register read returns the byte at the current offset in `rsp_rdata_o[7:0]`, with zero in the upper bits. The offset then advances by one.
- R5: Key 0x0000 is 4 bytes long and holds 0x51, 0x45, 0x4D, 0x55 at offsets 0 to 3.
- R6: Key 0x0001 is 4 bytes long and holds a little-endian 32-bit feature word. Bit 1 of that word equals parameter `DMA_EN` and all other bits are zero, so with `DMA_EN`=1 the bytes are 02 00 00 00.
- R7: When `DMA_EN`=1, a read of the transfer-address register returns byte lanes 0 to 7 equal to 0x51 0x45 0x4D 0x55 0x20 0x43 0x46 0x47. Lane i is bits [8i+7:8i] and holds the byte at address 0x10+i. When `DMA_EN`=0 the read returns zero. Writes to this register are ignored.
- R8: A read at or beyond the item length returns zero and leaves the offset saturated at the length. An unknown key has length 0.
- R9: User item i (0 ≤ i < `N_USER`) has key `USER_BASE`+i and length 5+3i. Its byte at offset o is (0xA0 + 16i + o) mod 256.
- R10: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both high. `rsp_valid_o` is high in exactly the following cycle and carries the read data; write responses carry zero.
- R11: `req_ready_o` is low whenever any side-port valid is high, and no bus request is accepted in that cycle. Among the side ports, select wins over skip, and skip wins over fetch. `dma_byte_o` always shows the byte at the current key and offset.
- R12: A side-port skip advances the offset by `dma_skip_len_i`, saturating at the item length. A fetch advances the offset by one, with the same saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request accepted when high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte address within the region |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata_o | output | 64 | Response read data |
| dma_sel_valid_i | input | 1 | Side port: select an item |
| dma_sel_key_i | input | 16 | Side port: key to select |
| dma_skip_valid_i | input | 1 | Side port: skip forward |
| dma_skip_len_i | input | 16 | Side port: skip byte count |
| dma_fetch_valid_i | input | 1 | Side port: consume the current byte |
| dma_byte_o | output | 8 | Byte at the current key and offset |

## Verification
The embedded assertions check on every cycle that:

- the offset never exceeds the length of the current item;
- a select always leaves the offset at zero and the new key in place;
- a response follows an accepted request by exactly one cycle, and only then;
- a data read never sets the upper response bits;
- a fetch inside the item advances by exactly one.

The item contents, the identification value, the ignored writes, the side-port priority and the bus stall can only be shown by the bench. It runs a behavioural model alongside the design through scenarios that cover these cases and walk past item ends.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;
  localparam int KEY_W  = 16;
  localparam int OFF_W  = 16;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 64;

  localparam logic [KEY_W-1:0] KEY_SIG  = 16'h0000;
  localparam logic [KEY_W-1:0] KEY_FEAT = 16'h0001;

  // identification word, lane 0 is lowest address
  localparam logic [DATA_W-1:0] ID_MAGIC = 64'h4746_4320_554D_4551;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_SEL  = 2'd1,
    REG_XADR = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    if (a < 5'd8)                   return REG_DATA;
    else if (a == 5'd8 || a == 5'd9) return REG_SEL;
    else if (a >= 5'd16 && a <= 5'd23) return REG_XADR;
    else                            return REG_NONE;
  endfunction
endpackage

// File: rtl/cfg_item_rom.sv
module cfg_item_rom
  import cfg_item_pkg::*;
#(
  parameter int               N_USER    = 4,
  parameter logic [KEY_W-1:0] USER_BASE = 16'h0020,
  parameter bit               DMA_EN    = 1'b1
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [OFF_W-1:0] len_o,
  output logic [7:0]       byte_o
);
  localparam int NU = (N_USER > 0) ? N_USER : 1;
  localparam logic [31:0] FEAT_WORD = DMA_EN ? 32'h0000_0002 : 32'h0000_0000;

  logic [NU-1:0]    hit;
  logic [OFF_W-1:0] ulen  [NU];
  logic [7:0]       ubyte [NU];

  for (genvar g = 0; g < NU; g++) begin : g_user
    assign hit[g]   = (N_USER > 0) && (key_i == KEY_W'(USER_BASE + KEY_W'(g)));
    assign ulen[g]  = OFF_W'(5 + 3 * g);
    assign ubyte[g] = (off_i < ulen[g]) ? 8'(8'hA0 + 8'(16 * g)) + off_i[7:0] : 8'h00;
  end

  logic [7:0] sig_byte;
  always_comb begin
    unique case (off_i[1:0])
      2'd0: sig_byte = 8'h51;
      2'd1: sig_byte = 8'h45;
      2'd2: sig_byte = 8'h4D;
      default: sig_byte = 8'h55;
    endcase
  end

  always_comb begin
    len_o  = '0;
    byte_o = 8'h00;
    if (key_i == KEY_SIG) begin
      len_o  = OFF_W'(4);
      byte_o = (off_i < OFF_W'(4)) ? sig_byte : 8'h00;
    end else if (key_i == KEY_FEAT) begin
      len_o  = OFF_W'(4);
      byte_o = (off_i < OFF_W'(4)) ? FEAT_WORD[8*off_i[1:0] +: 8] : 8'h00;
    end else begin
      for (int i = 0; i < NU; i++) begin
        if (hit[i]) begin
          len_o  = ulen[i];
          byte_o = ubyte[i];
        end
      end
    end
  end
endmodule

// File: rtl/cfg_cursor.sv
module cfg_cursor
  import cfg_item_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [KEY_W-1:0] sel_key_i,
  input  logic             adv_i,
  input  logic [OFF_W-1:0] adv_len_i,
  input  logic [OFF_W-1:0] item_len_i,
  output logic [KEY_W-1:0] key_o,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W:0]   sum;
  logic [OFF_W-1:0] off_nxt;

  assign sum     = {1'b0, off_o} + {1'b0, adv_len_i};
  assign off_nxt = (sum > {1'b0, item_len_i}) ? item_len_i : sum[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o <= KEY_SIG;
      off_o <= '0;
    end else if (sel_i) begin
      key_o <= sel_key_i;
      off_o <= '0;
    end else if (adv_i) begin
      off_o <= off_nxt;
    end
  end

  a_r8_off_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_o <= item_len_i);
  a_r3_sel_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> (off_o == '0) && (key_o == $past(sel_key_i)));
  a_r12_adv_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !sel_i) |=> (off_o >= $past(off_o)) && (key_o == $past(key_o)));
endmodule

// File: rtl/cfg_bus_regs.sv
module cfg_bus_regs
  import cfg_item_pkg::*;
#(
  parameter bit DMA_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_ready_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [KEY_W-1:0]  cur_key_i,
  input  logic [7:0]        cur_byte_i,
  output logic              sel_o,
  output logic [KEY_W-1:0]  sel_key_o,
  output logic              rd_adv_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  reg_sel_e          rsel;
  logic              acc;
  logic [DATA_W-1:0] rd_val;

  assign rsel      = decode_addr(req_addr_i);
  assign acc       = req_valid_i && req_ready_i;
  assign sel_o     = acc && req_write_i && (rsel == REG_SEL);
  assign sel_key_o = req_wdata_i[KEY_W-1:0];
  assign rd_adv_o  = acc && !req_write_i && (rsel == REG_DATA);

  always_comb begin
    unique case (rsel)
      REG_DATA: rd_val = {{(DATA_W-8){1'b0}}, cur_byte_i};
      REG_SEL:  rd_val = {{(DATA_W-KEY_W){1'b0}}, cur_key_i};
      REG_XADR: rd_val = DMA_EN ? ID_MAGIC : '0;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= acc;
      rsp_rdata_o <= (acc && !req_write_i) ? rd_val : '0;
    end
  end

  a_r10_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);
  a_r4_byte_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_adv_o |=> (rsp_rdata_o[DATA_W-1:8] == '0));
  a_r10_write_rsp_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_write_i) |=> (rsp_rdata_o == '0));
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfg_item_pkg::*;
#(
  parameter int               N_USER    = 4,
  parameter logic [KEY_W-1:0] USER_BASE = 16'h0020,
  parameter bit               DMA_EN    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              dma_sel_valid_i,
  input  logic [KEY_W-1:0]  dma_sel_key_i,
  input  logic              dma_skip_valid_i,
  input  logic [OFF_W-1:0]  dma_skip_len_i,
  input  logic              dma_fetch_valid_i,
  output logic [7:0]        dma_byte_o
);
  logic [KEY_W-1:0] key_q;
  logic [OFF_W-1:0] off_q, item_len;
  logic [7:0]       cur_byte;
  logic             bus_sel, bus_adv;
  logic [KEY_W-1:0] bus_key;
  logic             sel, adv;
  logic [KEY_W-1:0] sel_key;
  logic [OFF_W-1:0] adv_len;

  // side ports own the cursor whenever active
  assign req_ready_o = !(dma_sel_valid_i || dma_skip_valid_i || dma_fetch_valid_i);

  assign sel     = dma_sel_valid_i || bus_sel;
  assign sel_key = dma_sel_valid_i ? dma_sel_key_i : bus_key;
  assign adv     = !dma_sel_valid_i && (dma_skip_valid_i || dma_fetch_valid_i || bus_adv);
  assign adv_len = dma_skip_valid_i ? dma_skip_len_i : OFF_W'(1);

  cfg_item_rom #(.N_USER(N_USER), .USER_BASE(USER_BASE), .DMA_EN(DMA_EN)) u_rom (
    .key_i (key_q),
    .off_i (off_q),
    .len_o (item_len),
    .byte_o(cur_byte)
  );

  cfg_cursor u_cursor (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .sel_key_i (sel_key),
    .adv_i     (adv),
    .adv_len_i (adv_len),
    .item_len_i(item_len),
    .key_o     (key_q),
    .off_o     (off_q)
  );

  cfg_bus_regs #(.DMA_EN(DMA_EN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_ready_i(req_ready_o),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .cur_key_i  (key_q),
    .cur_byte_i (cur_byte),
    .sel_o      (bus_sel),
    .sel_key_o  (bus_key),
    .rd_adv_o   (bus_adv),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  assign dma_byte_o = cur_byte;

  a_r11_fetch_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_fetch_valid_i && !dma_sel_valid_i && !dma_skip_valid_i && off_q < item_len)
      |=> off_q == $past(off_q) + OFF_W'(1));
  a_r8_end_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q >= item_len) |-> (dma_byte_o == 8'h00));
  a_r11_bus_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_sel_valid_i && req_valid_i) |=> !rsp_valid_o);
endmodule

// File: tb/cfg_item_port_bench.sv
`timescale 1ns/1ps
module cfg_item_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        dsel = 1'b0, dskip = 1'b0, dfetch = 1'b0;
  logic [15:0] dsel_key = '0, dskip_len = '0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_rdata;
  logic [7:0]  dma_byte;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_key = 0, m_off = 0;
  bit m_rsp_valid = 1'b0;
  logic [63:0] m_rdata = '0;

  always #10 clk = ~clk;

  cfg_item_port u_cfg_item_port (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dma_sel_valid_i(dsel), .dma_sel_key_i(dsel_key),
    .dma_skip_valid_i(dskip), .dma_skip_len_i(dskip_len),
    .dma_fetch_valid_i(dfetch), .dma_byte_o(dma_byte)
  );

  function automatic int mlen(int k);
    if (k == 0 || k == 1) return 4;
    if (k >= 32 && k < 36) return 5 + 3 * (k - 32);
    return 0;
  endfunction

  function automatic int mbyte(int k, int o);
    int sig[4] = '{8'h51, 8'h45, 8'h4D, 8'h55};
    if (o >= mlen(k)) return 0;
    if (k == 0) return sig[o];
    if (k == 1) return (o == 0) ? 2 : 0;
    return (160 + 16 * (k - 32) + o) % 256;
  endfunction

  function automatic logic [63:0] magic();
    int lanes[8] = '{8'h51, 8'h45, 8'h4D, 8'h55, 8'h20, 8'h43, 8'h46, 8'h47};
    logic [63:0] v = '0;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = lanes[i][7:0];
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int sat(int v, int l);
    return (v > l) ? l : v;
  endfunction

  task automatic step(string tag);
    bit dma_any, acc;
    int a;
    dma_any = dsel || dskip || dfetch;
    @(posedge clk);
    acc = req_valid && !dma_any;
    a = int'(req_addr);
    m_rsp_valid = acc;
    m_rdata = '0;
    if (acc && !req_write) begin
      if (a < 8) m_rdata = 64'(mbyte(m_key, m_off));
      else if (a == 8 || a == 9) m_rdata = 64'(m_key);
      else if (a >= 16 && a <= 23) m_rdata = magic();
    end
    if (dsel) begin m_key = int'(dsel_key); m_off = 0; end
    else if (dskip) m_off = sat(m_off + int'(dskip_len), mlen(m_key));
    else if (dfetch) m_off = sat(m_off + 1, mlen(m_key));
    else if (acc && req_write && (a == 8 || a == 9)) begin m_key = int'(req_wdata[15:0]); m_off = 0; end
    else if (acc && !req_write && a < 8) m_off = sat(m_off + 1, mlen(m_key));
    @(negedge clk);
    check({tag, " rsp_valid"}, 64'(rsp_valid), 64'(m_rsp_valid));
    check({tag, " rsp_rdata"}, rsp_rdata, m_rdata);
    check({tag, " dma_byte"}, 64'(dma_byte), 64'(mbyte(m_key, m_off)));
    check({tag, " ready"}, 64'(req_ready), 64'(!dma_any));
    req_valid = 1'b0; req_write = 1'b0; dsel = 1'b0; dskip = 1'b0; dfetch = 1'b0;
  endtask

  task automatic bus_rd(int a, string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'(a);
    step(tag);
  endtask

  task automatic bus_wr(int a, logic [63:0] d, string tag);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 5'(a); req_wdata = d;
    step(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 ready", 64'(req_ready), 64'd1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 dma_byte", 64'(dma_byte), 64'h51);
    step("R1 idle");

    bus_rd(0, "R5 sig0");  bus_rd(3, "R5 sig1 R2");
    bus_rd(7, "R5 sig2 R2"); bus_rd(2, "R5 sig3");
    bus_rd(0, "R8 past end"); bus_rd(5, "R8 past end");

    bus_wr(8, 64'hFFFF_FFFF_FFFF_0001, "R3 select features");
    for (int i = 0; i < 5; i++) bus_rd(1, "R6 feature byte");
    bus_rd(8, "R3 selector readback");

    bus_rd(16, "R7 id read");
    bus_rd(23, "R7 id read high");
    bus_wr(16, 64'h0123_4567_89AB_CDEF, "R7 write ignored");
    bus_rd(17, "R7 id after write");

    bus_rd(12, "R2 unmapped read");
    bus_wr(10, 64'h0022, "R2 unmapped write");
    bus_rd(24, "R2 unmapped read high");
    bus_rd(9, "R2 selector key kept");

    bus_wr(9, 64'hABCD_0021, "R3 select user");
    for (int i = 0; i < 10; i++) bus_rd(4, "R9 user item");

    bus_wr(8, 64'h0005, "R8 unknown key");
    bus_rd(0, "R8 unknown read"); bus_rd(6, "R8 unknown read");

    bus_wr(8, 64'h0020, "R10 select");
    for (int i = 0; i < 3; i++) bus_rd(0, "R10 back to back");
    step("R10 idle");

    dsel = 1'b1; dsel_key = 16'h0023; step("R11 side select");
    for (int i = 0; i < 3; i++) begin dfetch = 1'b1; step("R12 fetch"); end
    dskip = 1'b1; dskip_len = 16'd5; step("R12 skip");
    dskip = 1'b1; dskip_len = 16'd100; step("R12 skip saturate");
    dfetch = 1'b1; step("R8 fetch past end");

    dsel = 1'b1; dsel_key = 16'h0022; dskip = 1'b1; dskip_len = 16'd3; dfetch = 1'b1;
    step("R11 priority select");
    dskip = 1'b1; dskip_len = 16'd2; dfetch = 1'b1; step("R11 priority skip");
    dfetch = 1'b1; step("R12 fetch");

    req_valid = 1'b1; req_addr = 5'd0; dfetch = 1'b1; step("R11 bus stalled");
    req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd8; req_wdata = 64'h1; dsel = 1'b1;
    dsel_key = 16'h0000; step("R11 bus write stalled");
    bus_rd(0, "R4 data after side select");
    bus_rd(8, "R3 key after side select");
    step("R10 idle end");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule